// File: doc/BRIEF.md
# Self-Feedback Counter with Decoded Clear and Load

A 4-bit synchronous up-counter whose synchronous clear and synchronous parallel load are both decoded from its own state bits. Because the decoded controls fire in certain states, the 16 states break into several short, disjoint loops. Which loop the counter runs in depends on the state it starts from. The main loop is 1100, 1101, 1110 and back to 1100. The other states are reached only from particular starts, and most of them collapse to 0000.

A test preset input forces any starting state on the next clock edge, so every transition can be checked one state at a time. The block has no data stream, so it has no valid/ready handshake. All pins are plain control and state lines that are sampled on the rising clock edge.

Top module: `cfbk_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0000. The reset acts asynchronously.
- R2: When both decoded controls are active, clear wins over load. States 0110 and 0111 go to 0000.
- R3: Clear is active when bit 3 is 0 and bit 1 is 1. The next rising edge then makes `count` equal to 0000.
- R4: Load is active when bit 2 and bit 1 are both 1. When clear is inactive, the next edge makes `count` equal to 1100.
- R5: When neither clear nor load is active, `count` increments by one on each rising edge.
- R6: When `preset_en` is 1, the next edge makes `count` equal to `preset_val`. The preset overrides clear, load and increment.
- R7: Starting from 0000, the counter returns to 0000 after three edges (0000, 0001, 0010). Starting from 1000, it passes through 1001, 1010 and 1011, enters 1100, and then repeats 1100, 1101, 1110 with period three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset_en | input | 1 | Force `preset_val` into the state on the next edge |
| preset_val | input | 4 | Starting state to force |
| count | output | 4 | Counter state, bit 3 is the MSB |

## Verification
A wrong internal state is visible on `count` immediately, because the state register drives the port directly. A bad transition is therefore seen one edge after the faulty decision. A wrong clear or load decode typically sends the counter into the wrong loop. For example, a lost clear priority leaves 0110 at 1100 instead of 0000, and that error persists in every later edge. Because of this, both single-step checks from each preset state and multi-edge runs expose it.

// File: rtl/cfbk_pkg.sv
package cfbk_pkg;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic clr;
    logic ld;
  } fb_t;
endpackage

// File: rtl/cfbk_decode.sv
module cfbk_decode
  import cfbk_pkg::*;
#(
  parameter int W       = CNT_W,
  parameter int CLR_OFF = 3,
  parameter int CLR_ON  = 1,
  parameter int LD_A    = 2,
  parameter int LD_B    = 1
) (
  input  logic [W-1:0] q,
  output fb_t          fb
);
  // clear when the "off" tap is low and the "on" tap is high
  always_comb begin
    fb.clr = ~q[CLR_OFF] & q[CLR_ON];
    fb.ld  = q[LD_A] & q[LD_B];
  end
endmodule

// File: rtl/cfbk_next.sv
module cfbk_next
  import cfbk_pkg::*;
#(
  parameter int           W          = CNT_W,
  parameter logic [W-1:0] LOAD_VALUE = 4'b1100
) (
  input  logic [W-1:0] q,
  input  fb_t          fb,
  input  logic         preset_en,
  input  logic [W-1:0] preset_val,
  output logic [W-1:0] d
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  always_comb begin
    if (preset_en)   d = preset_val;
    else if (fb.clr) d = ZERO;
    else if (fb.ld)  d = LOAD_VALUE;
    else             d = q + ONE;
  end
endmodule

// File: rtl/cfbk_reg.sv
module cfbk_reg #(
  parameter int           W           = 4,
  parameter logic [W-1:0] RESET_VALUE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VALUE;
    else        q <= d;
  end
endmodule

// File: rtl/cfbk_counter.sv
module cfbk_counter
  import cfbk_pkg::*;
#(
  parameter int           W          = CNT_W,
  parameter logic [W-1:0] LOAD_VALUE = 4'b1100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         preset_en,
  input  logic [W-1:0] preset_val,
  output logic [W-1:0] count
);
  fb_t         fb;
  logic [W-1:0] d;

  cfbk_decode #(.W(W)) u_dec (
    .q  (count),
    .fb (fb)
  );

  cfbk_next #(.W(W), .LOAD_VALUE(LOAD_VALUE)) u_nxt (
    .q          (count),
    .fb         (fb),
    .preset_en  (preset_en),
    .preset_val (preset_val),
    .d          (d)
  );

  cfbk_reg #(.W(W), .RESET_VALUE('0)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (d),
    .q     (count)
  );
endmodule

// File: rtl/cfbk_counter_chk.sv
module cfbk_counter_chk #(
  parameter int           W          = 4,
  parameter logic [W-1:0] LOAD_VALUE = 4'b1100
) (
  input logic         clk,
  input logic         rst_n,
  input logic         preset_en,
  input logic [W-1:0] preset_val,
  input logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> count == '0); // R1

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_en && count[2] && count[1] && !count[3]) |=> count == '0); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_en && !count[3] && count[1]) |=> count == '0); // R3

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_en && count[3] && count[2] && count[1]) |=> count == LOAD_VALUE); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_en && !count[1]) |=> count == $past(count) + ONE); // R5

  AST_PRESET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    preset_en |=> count == $past(preset_val)); // R6
endmodule

bind cfbk_counter cfbk_counter_chk #(.W(W), .LOAD_VALUE(LOAD_VALUE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .preset_en  (preset_en),
  .preset_val (preset_val),
  .count      (count)
);

// File: tb/sim_cfbk_counter.sv
`timescale 1ns/1ps
module sim_cfbk_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       preset_en = 1'b0;
  logic [3:0] preset_val = '0;
  logic [3:0] count;
  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] cur;

  always #5 clk = ~clk;

  cfbk_counter u0 (
    .clk(clk), .rst_n(rst_n), .preset_en(preset_en),
    .preset_val(preset_val), .count(count)
  );

  function automatic logic [3:0] model(input logic [3:0] s, input logic pe,
                                        input logic [3:0] pv);
    if (pe) return pv;
    if (!s[3] && s[1]) return 4'b0000;
    if (s[2] && s[1]) return 4'b1100;
    return s + 4'd1;
  endfunction

  function automatic string req_of(input logic [3:0] s, input logic pe);
    if (pe) return "R6";
    if (!s[3] && s[1] && s[2]) return "R2";
    if (!s[3] && s[1]) return "R3";
    if (s[2] && s[1]) return "R4";
    return "R5";
  endfunction

  task automatic check(input string rq, input logic [3:0] exp);
    n_cmp++;
    if (count !== exp) begin
      n_bad++;
      $display("FAIL %s: count=%b expected=%b", rq, count, exp);
    end
  endtask

  // called at negedge: drive, advance one edge, compare at next negedge
  task automatic step(input logic pe, input logic [3:0] pv, input string rq);
    logic [3:0] exp;
    string r;
    exp = model(cur, pe, pv);
    r = (rq == "") ? req_of(cur, pe) : rq;
    preset_en = pe;
    preset_val = pv;
    @(posedge clk);
    @(negedge clk);
    check(r, exp);
    cur = exp;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: count=%b expected=finish", count);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R1", 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    cur = 4'b0000;
    // R7: loop from 0000
    step(0, 0, "R7"); step(0, 0, "R7"); step(0, 0, "R7");
    // R7: from 1000 into main loop
    step(1, 4'b1000, "R6");
    for (int i = 0; i < 10; i++) step(0, 0, "R7");
    // every state: preset then one free step
    for (int s = 0; s < 16; s++) begin
      step(1, 4'(s), "R6");
      step(0, 0, "");
    end
    // R2 corner: 0110 and 0111 both clear
    step(1, 4'b0110, "R6"); step(0, 0, "R2");
    step(1, 4'b0111, "R6"); step(0, 0, "R2");
    // R6 preset over active clear and load
    step(1, 4'b0011, "R6"); step(1, 4'b0101, "R6");
    step(1, 4'b1110, "R6"); step(1, 4'b1001, "R6");
    // random mix
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 4) == 0) step(1, 4'($urandom), "");
      else step(0, 4'($urandom), "");
    end
    // R1: asynchronous reset mid-run
    step(1, 4'b1101, "R6");
    #2 rst_n = 1'b0;
    #1 check("R1", 4'b0000);
    @(negedge clk);
    check("R1", 4'b0000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule